// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a small processor-style system between eight states built on six power modes: Normal, Idle, Suspend, Snooze, Stop and Shutdown. Two more states handle exits. One restarts the oscillator after a clock-gated sleep. The other issues a reset pulse after a power-off sleep. Software requests a mode through one-cycle write strobes. Before it accepts a request, the block checks that the request is legal. It then drives the core and peripheral clock gates, the clock enable for the always-on timers, the two high-frequency oscillator enables, the regulator bias level, the low-dropout regulator enable, the internal power nets and the pin-hold control.

Each mode has its own exits. An interrupt ends Idle. Any of five wake sources ends Suspend and Snooze, and execution then resumes without a reset. Reset inputs end Stop and Shutdown. Shutdown listens only to the reset pin; power-on reset is the block's own asynchronous reset. After a clock-gated sleep, the clocks come back only once the primary oscillator is stable. Stability is signalled either by a ready input or by a count of low-frequency ticks, and a parameter picks which.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (Normal), rst_req and err_flag are 0, and the control outputs {core_clk_en, periph_clk_en, tmr34_clk_en, hfo0_en, hfo1_en, bias_low, ldo_en, nets_on, pin_hold} equal 9'b111110110.
- R2: In Normal, a req_idle strobe moves the block to mode 1 (Idle) with controls 9'b011110110. Wake lines have no effect in Idle. irq_any high returns the block to Normal on the next clock.
- R3: In Normal with clk_on_hfo0 high, a req_suspend strobe enters mode 2 (Suspend) with controls 9'b001000110. Both oscillators are off, the bias is normal and the timer clock stays on.
- R4: In Normal with clk_on_hfo0 high, a req_snooze strobe enters mode 3 (Snooze) with controls 9'b001001110. This is the same as Suspend except that the regulator bias is low.
- R5: A Suspend or Snooze request made while clk_on_hfo0 is low leaves the block in Normal and sets err_flag. err_flag stays set until an err_clr strobe. When a set and a clear fall in the same cycle, the set wins.
- R6: In Suspend or Snooze, the block moves to mode 6 (oscillator restart) with controls 9'b001100110 and no rst_req. The trigger is any high bit of wake_src (bit 0 timer 4, bit 1 SPI, bit 2 I2C slave, bit 3 port match) or a high-to-low change of cmp0_out. A low-to-high change of cmp0_out does not wake the block.
- R7: Mode 6 returns to Normal on the clock where the oscillator is ready. With OSC_READY_PRESENT=1 that clock is the one where osc_ready is high. With OSC_READY_PRESENT=0 it is the clock of the LF_WAIT-th lf_tick counted in mode 6.
- R8: req_stop with stop_cfg low enters mode 4 (Stop) with controls 9'b000000101. Either rst_pin or rst_other ends Stop.
- R9: req_stop with stop_cfg high enters mode 5 (Shutdown) with controls 9'b000000001. Only rst_pin ends Shutdown; rst_other, irq_any and wake lines are ignored.
- R10: Leaving Stop or Shutdown passes through mode 7 for exactly one cycle, with rst_req high and controls 9'b000100110. The block then returns to Normal.
- R11: In Normal, a req_idle, req_suspend or req_snooze strobe is dropped when irq_any, a wake line or a cmp0_out fall occurs in the same cycle; req_stop is never dropped. When several requests coincide, stop wins over snooze, snooze over suspend and suspend over idle. If the winning request is refused, nothing else is taken.
- R12: Request strobes arriving outside Normal are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_idle | input | 1 | Idle request strobe |
| req_suspend | input | 1 | Suspend request strobe |
| req_snooze | input | 1 | Snooze request strobe |
| req_stop | input | 1 | Stop/Shutdown request strobe |
| stop_cfg | input | 1 | 0 selects Stop, 1 selects Shutdown |
| clk_on_hfo0 | input | 1 | System clock is on the primary high-frequency oscillator |
| err_clr | input | 1 | Clears err_flag |
| irq_any | input | 1 | An enabled interrupt is pending |
| wake_src | input | NWAKE | Wake lines: timer 4, SPI, I2C slave, port match |
| cmp0_out | input | 1 | Comparator 0 output; its falling edge wakes |
| lf_tick | input | 1 | One-cycle pulse per low-frequency oscillator period |
| osc_ready | input | 1 | Primary oscillator stable |
| rst_pin | input | 1 | Reset pin request |
| rst_other | input | 1 | Any other reset source |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| tmr34_clk_en | output | 1 | Always-on timer clock enable |
| hfo0_en | output | 1 | Primary high-frequency oscillator enable |
| hfo1_en | output | 1 | Second high-frequency oscillator enable |
| bias_low | output | 1 | Regulator in low-bias mode |
| ldo_en | output | 1 | Internal low-dropout regulator enable |
| nets_on | output | 1 | Internal power nets on |
| pin_hold | output | 1 | Pins hold their state |
| rst_req | output | 1 | One-cycle reset request |
| err_flag | output | 1 | Sticky illegal-request flag |
| mode_o | output | 3 | Current state code 0..7 |

## Verification
Every state change happens on the clock that samples its cause, and the control outputs decode the state without further registers. Each result is therefore due exactly one clock after its stimulus. The bench drives inputs just after a falling edge and samples at the next falling edge. The exit from mode 6 is the only counted delay. The bench checks that the block is still in mode 6 after LF_WAIT-1 ticks and back in Normal after the LF_WAIT-th tick. A second instance that uses the ready input must leave mode 6 in the very cycle osc_ready is high.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL   = 3'd0,
    PM_IDLE     = 3'd1,
    PM_SUSPEND  = 3'd2,
    PM_SNOOZE   = 3'd3,
    PM_STOP     = 3'd4,
    PM_SHUTDOWN = 3'd5,
    PM_WAKEUP   = 3'd6,
    PM_RSTOUT   = 3'd7
  } pm_state_t;

  typedef struct packed {
    logic core;
    logic periph;
    logic tmr34;
    logic hfo0;
    logic hfo1;
    logic bias_low;
    logic ldo;
    logic nets;
    logic hold;
  } pm_ctl_t;

  // Control pattern for each state.
  function automatic pm_ctl_t pm_ctl_of(pm_state_t s);
    pm_ctl_t c;
    c = '{core: 1'b0, periph: 1'b0, tmr34: 1'b0, hfo0: 1'b0, hfo1: 1'b0,
          bias_low: 1'b0, ldo: 1'b1, nets: 1'b1, hold: 1'b0};
    unique case (s)
      PM_NORMAL:   begin c.core = 1'b1; c.periph = 1'b1; c.tmr34 = 1'b1; c.hfo0 = 1'b1; c.hfo1 = 1'b1; end
      PM_IDLE:     begin c.periph = 1'b1; c.tmr34 = 1'b1; c.hfo0 = 1'b1; c.hfo1 = 1'b1; end
      PM_SUSPEND:  begin c.tmr34 = 1'b1; end
      PM_SNOOZE:   begin c.tmr34 = 1'b1; c.bias_low = 1'b1; end
      PM_STOP:     begin c.nets = 1'b0; c.hold = 1'b1; end
      PM_SHUTDOWN: begin c.nets = 1'b0; c.hold = 1'b1; c.ldo = 1'b0; end
      PM_WAKEUP:   begin c.tmr34 = 1'b1; c.hfo0 = 1'b1; end
      PM_RSTOUT:   begin c.hfo0 = 1'b1; end
      default:     begin c.hfo0 = 1'b0; end
    endcase
    return c;
  endfunction

  // Clock-gated sleep states that listen to the wake lines.
  function automatic logic pm_is_gated(pm_state_t s);
    return (s == PM_SUSPEND) || (s == PM_SNOOZE);
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int NWAKE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWAKE-1:0] wake_src,
  input  logic             cmp0_out,
  output logic             cmp0_fall,
  output logic             wake_hit
);
  logic cmp0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp0_q <= 1'b0;
    else        cmp0_q <= cmp0_out;
  end

  assign cmp0_fall = cmp0_q & ~cmp0_out;
  assign wake_hit  = (|wake_src) | cmp0_fall;
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
  parameter bit OSC_READY_PRESENT = 1'b0,
  parameter int LF_WAIT           = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic lf_tick,
  input  logic osc_ready,
  output logic osc_done
);
  generate
    if (OSC_READY_PRESENT) begin : g_ready
      assign osc_done = active & osc_ready;
    end else begin : g_count
      localparam int CW = $clog2(LF_WAIT + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!active)           cnt <= '0;
        else if (lf_tick && !osc_done) cnt <= cnt + 1'b1;
      end
      assign osc_done = active & lf_tick & (cnt == CW'(LF_WAIT - 1));
    end
  endgenerate
endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
  import pwr_mode_pkg::*;
(
  input  pm_state_t state,
  output pm_ctl_t   ctl,
  output logic      rst_req
);
  assign ctl     = pm_ctl_of(state);
  assign rst_req = (state == PM_RSTOUT);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int NWAKE             = 4,
  parameter bit OSC_READY_PRESENT = 1'b0,
  parameter int LF_WAIT           = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_idle,
  input  logic             req_suspend,
  input  logic             req_snooze,
  input  logic             req_stop,
  input  logic             stop_cfg,
  input  logic             clk_on_hfo0,
  input  logic             err_clr,
  input  logic             irq_any,
  input  logic [NWAKE-1:0] wake_src,
  input  logic             cmp0_out,
  input  logic             lf_tick,
  input  logic             osc_ready,
  input  logic             rst_pin,
  input  logic             rst_other,
  output logic             core_clk_en,
  output logic             periph_clk_en,
  output logic             tmr34_clk_en,
  output logic             hfo0_en,
  output logic             hfo1_en,
  output logic             bias_low,
  output logic             ldo_en,
  output logic             nets_on,
  output logic             pin_hold,
  output logic             rst_req,
  output logic             err_flag,
  output logic [2:0]       mode_o
);
  pm_state_t state, state_n;
  pm_ctl_t   ctl;

  // Named internal events, also used by the checker.
  logic wake_hit, cmp0_fall, osc_done;
  logic in_normal, req_blocked, gated_req, bad_clk_req, any_reset;

  pwr_wake_detect #(.NWAKE(NWAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .wake_src(wake_src), .cmp0_out(cmp0_out),
    .cmp0_fall(cmp0_fall), .wake_hit(wake_hit)
  );

  pwr_osc_timer #(.OSC_READY_PRESENT(OSC_READY_PRESENT), .LF_WAIT(LF_WAIT)) u_osc (
    .clk(clk), .rst_n(rst_n), .active(state == PM_WAKEUP), .lf_tick(lf_tick),
    .osc_ready(osc_ready), .osc_done(osc_done)
  );

  pwr_gate_decode u_dec (.state(state), .ctl(ctl), .rst_req(rst_req));

  assign in_normal   = (state == PM_NORMAL);
  assign req_blocked = irq_any | wake_hit;
  assign gated_req   = req_snooze | req_suspend;
  assign bad_clk_req = in_normal & ~req_stop & ~req_blocked & gated_req & ~clk_on_hfo0;
  assign any_reset   = rst_pin | rst_other;

  always_comb begin
    state_n = state;
    unique case (state)
      PM_NORMAL: begin
        if (req_stop)                   state_n = stop_cfg ? PM_SHUTDOWN : PM_STOP;
        else if (!req_blocked) begin
          if (req_snooze)               state_n = clk_on_hfo0 ? PM_SNOOZE : PM_NORMAL;
          else if (req_suspend)         state_n = clk_on_hfo0 ? PM_SUSPEND : PM_NORMAL;
          else if (req_idle)            state_n = PM_IDLE;
        end
      end
      PM_IDLE:     if (irq_any)   state_n = PM_NORMAL;
      PM_SUSPEND,
      PM_SNOOZE:   if (wake_hit)  state_n = PM_WAKEUP;
      PM_WAKEUP:   if (osc_done)  state_n = PM_NORMAL;
      PM_STOP:     if (any_reset) state_n = PM_RSTOUT;
      PM_SHUTDOWN: if (rst_pin)   state_n = PM_RSTOUT;
      PM_RSTOUT:                  state_n = PM_NORMAL;
      default:                    state_n = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PM_NORMAL;
    else        state <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_flag <= 1'b0;
    else if (bad_clk_req) err_flag <= 1'b1;
    else if (err_clr)     err_flag <= 1'b0;
  end

  assign core_clk_en   = ctl.core;
  assign periph_clk_en = ctl.periph;
  assign tmr34_clk_en  = ctl.tmr34;
  assign hfo0_en       = ctl.hfo0;
  assign hfo1_en       = ctl.hfo1;
  assign bias_low      = ctl.bias_low;
  assign ldo_en        = ctl.ldo;
  assign nets_on       = ctl.nets;
  assign pin_hold      = ctl.hold;
  assign mode_o        = state;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       irq_any,
  input logic       wake_hit,
  input logic       clk_on_hfo0,
  input logic       err_flag,
  input logic       err_clr,
  input logic       rst_req,
  input logic       rst_pin,
  input logic       rst_other
);
  a_r2_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && irq_any) |=> (mode_o == 3'd0));

  a_r3_entry_needs_hfo: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd2 || mode_o == 3'd3) && $past(mode_o) == 3'd0) |-> $past(clk_on_hfo0));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r6_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_o == 3'd2 || mode_o == 3'd3) && wake_hit) |=> (mode_o == 3'd6 && !rst_req));

  a_r8_stop_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && (rst_pin || rst_other)) |=> rst_req);

  a_r9_shutdown_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && !rst_pin) |=> (mode_o == 3'd5));

  a_r10_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!rst_req && mode_o == 3'd0));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .irq_any(irq_any), .wake_hit(wake_hit),
  .clk_on_hfo0(clk_on_hfo0), .err_flag(err_flag), .err_clr(err_clr), .rst_req(rst_req),
  .rst_pin(rst_pin), .rst_other(rst_other)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWAKE      = 4;
  localparam int LF_WAIT    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_idle = 0, req_suspend = 0, req_snooze = 0, req_stop = 0;
  logic stop_cfg = 0, clk_on_hfo0 = 1, err_clr = 0, irq_any = 0;
  logic [NWAKE-1:0] wake_src = '0;
  logic cmp0_out = 0, lf_tick = 0, osc_ready = 0, rst_pin = 0, rst_other = 0;

  logic [8:0] ctl_a, ctl_b;
  logic rst_req_a, rst_req_b, err_a, err_b;
  logic [2:0] mode_a, mode_b;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.NWAKE(NWAKE), .OSC_READY_PRESENT(1'b0), .LF_WAIT(LF_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_suspend(req_suspend),
    .req_snooze(req_snooze), .req_stop(req_stop), .stop_cfg(stop_cfg),
    .clk_on_hfo0(clk_on_hfo0), .err_clr(err_clr), .irq_any(irq_any), .wake_src(wake_src),
    .cmp0_out(cmp0_out), .lf_tick(lf_tick), .osc_ready(osc_ready), .rst_pin(rst_pin),
    .rst_other(rst_other),
    .core_clk_en(ctl_a[8]), .periph_clk_en(ctl_a[7]), .tmr34_clk_en(ctl_a[6]),
    .hfo0_en(ctl_a[5]), .hfo1_en(ctl_a[4]), .bias_low(ctl_a[3]), .ldo_en(ctl_a[2]),
    .nets_on(ctl_a[1]), .pin_hold(ctl_a[0]), .rst_req(rst_req_a), .err_flag(err_a),
    .mode_o(mode_a)
  );

  pwr_mode_seq #(.NWAKE(NWAKE), .OSC_READY_PRESENT(1'b1), .LF_WAIT(LF_WAIT)) u_dut_rdy (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_suspend(req_suspend),
    .req_snooze(req_snooze), .req_stop(req_stop), .stop_cfg(stop_cfg),
    .clk_on_hfo0(clk_on_hfo0), .err_clr(err_clr), .irq_any(irq_any), .wake_src(wake_src),
    .cmp0_out(cmp0_out), .lf_tick(lf_tick), .osc_ready(osc_ready), .rst_pin(rst_pin),
    .rst_other(rst_other),
    .core_clk_en(ctl_b[8]), .periph_clk_en(ctl_b[7]), .tmr34_clk_en(ctl_b[6]),
    .hfo0_en(ctl_b[5]), .hfo1_en(ctl_b[4]), .bias_low(ctl_b[3]), .ldo_en(ctl_b[2]),
    .nets_on(ctl_b[1]), .pin_hold(ctl_b[0]), .rst_req(rst_req_b), .err_flag(err_b),
    .mode_o(mode_b)
  );

  // Expected controls per mode, taken from the requirement table.
  function automatic logic [8:0] exp_ctl(input logic [2:0] m);
    case (m)
      3'd0: return 9'b111110110;
      3'd1: return 9'b011110110;
      3'd2: return 9'b001000110;
      3'd3: return 9'b001001110;
      3'd4: return 9'b000000101;
      3'd5: return 9'b000000001;
      3'd6: return 9'b001100110;
      default: return 9'b000100110;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Mode, controls and reset pulse of one instance.
  task automatic chk_a(input string tag, input logic [2:0] m);
    chk({tag, " mode"}, int'(mode_a), int'(m));
    chk({tag, " ctl"}, int'(ctl_a), int'(exp_ctl(m)));
    chk({tag, " rst_req"}, int'(rst_req_a), int'(m == 3'd7));
  endtask

  task automatic chk_b(input string tag, input logic [2:0] m);
    chk({tag, " rdy mode"}, int'(mode_b), int'(m));
    chk({tag, " rdy ctl"}, int'(ctl_b), int'(exp_ctl(m)));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Leave oscillator restart: ready for the ready-input instance, ticks for the other.
  task automatic exit_wake(input string tag);
    osc_ready = 1; cyc(); osc_ready = 0;
    chk_b({tag, " R7 ready exit"}, 3'd0);
    chk_a({tag, " R7 ready ignored"}, 3'd6);
    lf_tick = 1;
    for (int k = 0; k < LF_WAIT - 1; k++) cyc();
    chk_a({tag, " R7 one tick short"}, 3'd6);
    cyc();
    lf_tick = 0;
    chk_a({tag, " R7 count exit"}, 3'd0);
    chk_b({tag, " R7 stays normal"}, 3'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_a("R1", 3'd0);
    chk_b("R1", 3'd0);
    chk("R1 err", int'(err_a), 0);

    // R2 idle entry, wake lines ignored, interrupt exit
    req_idle = 1; cyc(); req_idle = 0;
    chk_a("R2 enter", 3'd1);
    wake_src = 4'b1111; cyc(); wake_src = '0;
    chk_a("R2 wake ignored", 3'd1);
    req_snooze = 1; cyc(); req_snooze = 0;
    chk_a("R12 req in idle", 3'd1);
    irq_any = 1; cyc(); irq_any = 0;
    chk_a("R2 exit", 3'd0);

    // R5 illegal clock source
    clk_on_hfo0 = 0;
    req_suspend = 1; cyc(); req_suspend = 0;
    chk_a("R5 suspend refused", 3'd0);
    chk("R5 err set", int'(err_a), 1);
    cyc();
    chk("R5 err sticky", int'(err_a), 1);
    err_clr = 1; cyc(); err_clr = 0;
    chk("R5 err cleared", int'(err_a), 0);
    req_snooze = 1; err_clr = 1; cyc(); req_snooze = 0; err_clr = 0;
    chk_a("R5 snooze refused", 3'd0);
    chk("R5 set beats clear", int'(err_a), 1);
    err_clr = 1; cyc(); err_clr = 0;
    clk_on_hfo0 = 1;

    // R3 R4 R6 R7 sweep over both gated modes and all five wake sources
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s <= NWAKE; s++) begin
        automatic logic [2:0] tgt = (m == 0) ? 3'd2 : 3'd3;
        automatic string tg = $sformatf("m%0d s%0d", tgt, s);
        if (m == 0) req_suspend = 1; else req_snooze = 1;
        cyc();
        req_suspend = 0; req_snooze = 0;
        if (m == 0) chk_a({tg, " R3 enter"}, tgt); else chk_a({tg, " R4 enter"}, tgt);
        chk_b({tg, " R3 R4 enter"}, tgt);
        req_stop = 1; req_idle = 1; cyc(); req_stop = 0; req_idle = 0;
        chk_a({tg, " R12 ignored"}, tgt);
        if (s == NWAKE) begin
          cmp0_out = 1; cyc();
          chk_a({tg, " R6 rising ignored"}, tgt);
          cmp0_out = 0; cyc();
        end else begin
          wake_src[s] = 1'b1; cyc(); wake_src = '0;
        end
        chk_a({tg, " R6 wake"}, 3'd6);
        chk_b({tg, " R6 wake"}, 3'd6);
        exit_wake(tg);
      end
    end

    // R11 same-cycle conflicts
    req_idle = 1; irq_any = 1; cyc(); req_idle = 0; irq_any = 0;
    chk_a("R11 idle vs irq", 3'd0);
    req_suspend = 1; wake_src = 4'b0100; cyc(); req_suspend = 0; wake_src = '0;
    chk_a("R11 suspend vs wake", 3'd0);
    clk_on_hfo0 = 0;
    req_snooze = 1; wake_src = 4'b0001; cyc(); req_snooze = 0; wake_src = '0;
    chk("R11 dropped no err", int'(err_a), 0);
    req_snooze = 1; req_idle = 1; cyc(); req_snooze = 0; req_idle = 0;
    chk_a("R11 refused blocks idle", 3'd0);
    err_clr = 1; cyc(); err_clr = 0;
    clk_on_hfo0 = 1;
    req_idle = 1; req_suspend = 1; req_snooze = 1; cyc();
    req_idle = 0; req_suspend = 0; req_snooze = 0;
    chk_a("R11 snooze wins", 3'd3);
    wake_src = 4'b1000; cyc(); wake_src = '0;
    exit_wake("R11");

    // R8 Stop, both reset exits; R10 pulse
    for (int r = 0; r < 2; r++) begin
      stop_cfg = 0;
      req_stop = 1; irq_any = 1; req_idle = 1; cyc();
      req_stop = 0; irq_any = 0; req_idle = 0;
      chk_a("R8 R11 stop enter", 3'd4);
      cyc();
      chk_a("R8 stop holds", 3'd4);
      if (r == 0) rst_other = 1; else rst_pin = 1;
      cyc();
      rst_other = 0; rst_pin = 0;
      chk_a("R10 pulse", 3'd7);
      chk_b("R10 pulse", 3'd7);
      cyc();
      chk_a("R10 back to normal", 3'd0);
    end

    // R9 Shutdown
    stop_cfg = 1;
    req_stop = 1; req_snooze = 1; cyc(); req_stop = 0; req_snooze = 0;
    chk_a("R9 R11 shutdown enter", 3'd5);
    rst_other = 1; cyc(); rst_other = 0;
    chk_a("R9 other reset ignored", 3'd5);
    irq_any = 1; wake_src = 4'b1111; cyc(); irq_any = 0; wake_src = '0;
    chk_a("R9 wake ignored", 3'd5);
    rst_pin = 1; cyc(); rst_pin = 0;
    chk_a("R10 shutdown pulse", 3'd7);
    cyc();
    chk_a("R10 shutdown done", 3'd0);
    chk_b("R10 shutdown done", 3'd0);
    stop_cfg = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule